// File: doc/BRIEF.md
# Coarse-Fine Interval Digitizer

This block turns the time between a START event and a STOP event into a 12-bit code. A counter clocked by the reference clock counts the whole periods that elapse while the interval is open. An external locked delay line supplies sixteen evenly spaced phase taps of that clock. The block samples the taps once at the START event and once at the STOP event, and reduces each sample to a 4-bit phase code. The result combines the two parts: the coarse count scaled by sixteen, plus the START phase code, minus the STOP phase code. At 50 MHz one code step is 1.25 ns.

The block is a four-state machine. The states are `S_IDLE`, `S_RUN`, `S_MERGE` and `S_EMIT`, and there are four transitions:

- `S_IDLE` to `S_RUN` on a START rising edge.
- `S_RUN` to `S_MERGE` on a STOP rising edge.
- `S_MERGE` to `S_EMIT` unconditionally.
- `S_EMIT` to `S_IDLE` unconditionally.

START, STOP and the taps are registered on entry. The result is held on the outputs until the next result replaces it.

Top module: `cf_interval_tdc`

## Requirements
- R1: While reset is asserted and after it is released, `code_out` is 0, `code_valid` is 0 and `code_ovf` is 0 until the first result.
- R2: A tap vector is encoded as the smallest index i (1 to 15) whose bit differs from bit 0. A vector with all bits equal encodes as 0. Further transitions (bubbles) above the first one are ignored.
- R3: The coarse count equals the number of clock edges strictly between the edge that samples START high and the edge that samples STOP high.
- R4: The result is coarse·16 + fine(START taps) − fine(STOP taps). A negative result is clamped to 0.
- R5: `code_valid` is high for exactly one cycle: the cycle that begins two edges after the edge that samples STOP high.
- R6: If the coarse count would pass 255 (the interval spans more than 256 edges), `code_ovf` is 1 with the result and `code_out` is 4095.
- R7: `code_out` and `code_ovf` change only together with a `code_valid` pulse, and they hold their value in between.
- R8: A STOP edge while no interval is open has no effect. A START edge while an interval is open has no effect. Only rising edges count as events.
- R9: A new START clears the coarse count, the overflow state and the STOP phase register, so an earlier overflow does not carry into the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_taps | input | 16 | Delay-line phase taps, bit i is phase i |
| start_in | input | 1 | Interval start, rising edge is the event |
| stop_in | input | 1 | Interval stop, rising edge is the event |
| code_out | output | 12 | Digitized interval |
| code_valid | output | 1 | One-cycle strobe for a new result |
| code_ovf | output | 1 | Result came from a wrapped coarse count |

## Verification
The bench builds the block with its default 8-bit coarse counter and 4-bit fine code. With these values an overflow needs an interval of only 257 cycles, so the saturation limit and the interval just below it (coarse count 255) are both reached directly. The full 12-bit range, including the top code 4095, is reached without overflow. The small fine width also lets random stimulus cover every phase code at both ends, including negative totals that clamp to zero.

// File: rtl/cf_tdc_pkg.sv
package cf_tdc_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_MERGE = 2'd2,
        S_EMIT  = 2'd3
    } tdc_state_e;
endpackage

// File: rtl/cf_tdc_edge.sv
module cf_tdc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic q, q_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            q_d <= 1'b0;
        end else begin
            q   <= din;
            q_d <= q;
        end
    end

    assign rise = q & ~q_d;
endmodule

// File: rtl/cf_tdc_fine_enc.sv
module cf_tdc_fine_enc #(
    parameter int FW = 4,
    localparam int NT = 1 << FW
) (
    input  logic [NT-1:0] taps,
    output logic [FW-1:0] code
);
    logic found;

    always_comb begin
        code  = '0;
        found = 1'b0;
        for (int i = 1; i < NT; i++) begin
            if (!found && (taps[i] != taps[0])) begin
                code  = FW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cf_tdc_coarse_cnt.sv
module cf_tdc_coarse_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          wrapped
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            wrapped <= 1'b0;
        end else if (clr) begin
            cnt     <= '0;
            wrapped <= 1'b0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
            if (cnt == '1) wrapped <= 1'b1;
        end
    end
endmodule

// File: rtl/cf_tdc_merge.sv
module cf_tdc_merge #(
    parameter int CW = 8,
    parameter int FW = 4,
    localparam int OW = CW + FW,
    localparam int W  = OW + 2
) (
    input  logic [CW-1:0] coarse,
    input  logic          wrapped,
    input  logic [FW-1:0] fine_a,
    input  logic [FW-1:0] fine_b,
    output logic [OW-1:0] result
);
    logic signed [W-1:0] total;

    always_comb begin
        total = $signed({2'b00, coarse, {FW{1'b0}}})
              + $signed({{(CW+2){1'b0}}, fine_a})
              - $signed({{(CW+2){1'b0}}, fine_b});
        if (wrapped)
            result = '1;
        else if (total[W-1])
            result = '0;
        else
            result = total[OW-1:0];
    end
endmodule

// File: rtl/cf_interval_tdc.sv
module cf_interval_tdc #(
    parameter int CW = 8,
    parameter int FW = 4,
    localparam int NT = 1 << FW,
    localparam int OW = CW + FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] phase_taps,
    input  logic          start_in,
    input  logic          stop_in,
    output logic [OW-1:0] code_out,
    output logic          code_valid,
    output logic          code_ovf
);
    import cf_tdc_pkg::*;

    tdc_state_e    state, nxt;
    logic          start_evt, stop_evt;
    logic [NT-1:0] taps_q;
    logic [FW-1:0] fine_now, fine_a, fine_b;
    logic [CW-1:0] coarse;
    logic          wrapped;
    logic [OW-1:0] merged;

    cf_tdc_edge u_start_edge (.clk(clk), .rst_n(rst_n), .din(start_in), .rise(start_evt));
    cf_tdc_edge u_stop_edge  (.clk(clk), .rst_n(rst_n), .din(stop_in),  .rise(stop_evt));

    always_ff @(posedge clk) begin
        if (!rst_n) taps_q <= '0;
        else        taps_q <= phase_taps;
    end

    cf_tdc_fine_enc #(.FW(FW)) u_fine (.taps(taps_q), .code(fine_now));

    cf_tdc_coarse_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr(state == S_IDLE && start_evt),
        .inc(state == S_RUN && !stop_evt),
        .cnt(coarse), .wrapped(wrapped)
    );

    cf_tdc_merge #(.CW(CW), .FW(FW)) u_merge (
        .coarse(coarse), .wrapped(wrapped),
        .fine_a(fine_a), .fine_b(fine_b), .result(merged)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start_evt) nxt = S_RUN;
            S_RUN:   if (stop_evt)  nxt = S_MERGE;
            S_MERGE: nxt = S_EMIT;
            S_EMIT:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_a   <= '0;
            fine_b   <= '0;
            code_out <= '0;
            code_ovf <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start_evt) begin
                    fine_a <= fine_now;
                    fine_b <= '0;
                end
                S_RUN: if (stop_evt) fine_b <= fine_now;
                S_MERGE: begin
                    code_out <= merged;
                    code_ovf <= wrapped;
                end
                default: ;
            endcase
        end
    end

    assign code_valid = (state == S_EMIT);
endmodule

// File: rtl/cf_interval_tdc_chk.sv
module cf_interval_tdc_chk #(
    parameter int OW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop_in,
    input logic [OW-1:0] code_out,
    input logic          code_valid,
    input logic          code_ovf
);
    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid);

    p_valid_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> ($past(stop_in, 3) && !$past(stop_in, 4)));

    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code_ovf) |-> (code_out == '1));

    p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_out) |-> code_valid);

    p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_ovf) |-> code_valid);
endmodule

bind cf_interval_tdc cf_interval_tdc_chk #(.OW(OW)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_in(stop_in),
    .code_out(code_out), .code_valid(code_valid), .code_ovf(code_ovf)
);

// File: tb/cf_interval_tdc_bench.sv
`timescale 1ns/1ps
module cf_interval_tdc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] phase_taps = '0;
    logic        start_in = 1'b0;
    logic        stop_in = 1'b0;
    logic [11:0] code_out;
    logic        code_valid;
    logic        code_ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cf_interval_tdc u_cf_interval_tdc (
        .clk(clk), .rst_n(rst_n), .phase_taps(phase_taps),
        .start_in(start_in), .stop_in(stop_in),
        .code_out(code_out), .code_valid(code_valid), .code_ovf(code_ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] therm(input int p, input bit pol);
        logic [15:0] v;
        for (int i = 0; i < 16; i++) v[i] = (i < p) ? pol : ~pol;
        return v;
    endfunction

    function automatic int fenc(input logic [15:0] v);
        for (int i = 1; i < 16; i++) if (v[i] != v[0]) return i;
        return 0;
    endfunction

    // Runs one interval; k = edge distance START->STOP; extra = cycle of an ignored second START (0: none)
    task automatic run(input int k, input logic [15:0] ts, input logic [15:0] tp,
                       input int extra, input string tag);
        int coarse, tot, exp_code;
        bit exp_ovf;
        coarse  = k - 1;
        exp_ovf = coarse > 255;
        tot     = coarse * 16 + fenc(ts) - fenc(tp);
        exp_code = exp_ovf ? 4095 : (tot < 0 ? 0 : tot);
        start_in = 1'b1; phase_taps = ts;
        @(negedge clk);
        start_in = 1'b0; phase_taps = ~ts;
        for (int j = 1; j < k; j++) begin
            start_in = (extra != 0 && j == extra);
            @(negedge clk);
            start_in = 1'b0;
        end
        stop_in = 1'b1; phase_taps = tp;
        @(negedge clk);
        stop_in = 1'b0; phase_taps = '0;
        check(code_valid == 1'b0, {"R5 early ", tag}, code_valid, 0);
        @(negedge clk);
        check(code_valid == 1'b0, {"R5 early2 ", tag}, code_valid, 0);
        @(negedge clk);
        check(code_valid == 1'b1, {"R5 strobe ", tag}, code_valid, 1);
        check(code_out == 12'(exp_code), {"R4 code ", tag}, code_out, exp_code);
        check(code_ovf == exp_ovf, {"R6 ovf ", tag}, code_ovf, exp_ovf);
        @(negedge clk);
        check(code_valid == 1'b0, {"R5 single ", tag}, code_valid, 0);
        check(code_out == 12'(exp_code), {"R7 hold ", tag}, code_out, exp_code);
        @(negedge clk);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] bub;
        int prev;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(code_out == 0 && code_valid == 0 && code_ovf == 0, "R1 in reset", code_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(code_out == 0 && code_valid == 0 && code_ovf == 0, "R1 after reset", code_out, 0);

        // R3/R4 directed: aligned phases
        run(1, therm(0, 1'b0), therm(0, 1'b0), 0, "R3 k1");
        run(5, therm(7, 1'b1), therm(3, 1'b0), 0, "R3 k5");
        // R4 negative clamp: coarse 0, START phase < STOP phase
        run(1, therm(2, 1'b1), therm(9, 1'b1), 0, "R4 clamp");
        // R2 bubble: extra flips above first transition ignored
        bub = therm(5, 1'b1); bub[9] = ~bub[9]; bub[12] = ~bub[12];
        run(3, bub, therm(0, 1'b1), 0, "R2 bubble");
        // R2 all-equal and top phase
        run(2, 16'hFFFF, therm(15, 1'b0), 0, "R2 edges");
        // R6 boundary: coarse 255 top code, no overflow
        run(256, therm(15, 1'b1), therm(0, 1'b1), 0, "R6 max");
        // R6 overflow
        run(257, therm(4, 1'b1), therm(4, 1'b1), 0, "R6 wrap");
        // R9 next short run clears overflow state
        run(4, therm(1, 1'b0), therm(1, 1'b0), 0, "R9 clear");
        // R8 second START inside interval ignored
        run(20, therm(6, 1'b1), therm(2, 1'b1), 8, "R8 restart");

        // R8 stray STOP while idle: no strobe, outputs unchanged
        prev = code_out;
        stop_in = 1'b1;
        @(negedge clk);
        stop_in = 1'b0;
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            check(code_valid == 1'b0 && code_out == 12'(prev), "R8 idle stop", code_out, prev);
        end

        // R8 held START is one event: interval still closes on STOP
        start_in = 1'b1; phase_taps = therm(3, 1'b1);
        @(negedge clk);
        phase_taps = '0;
        repeat (5) @(negedge clk);
        start_in = 1'b0;
        stop_in = 1'b1; phase_taps = therm(3, 1'b1);
        @(negedge clk);
        stop_in = 1'b0;
        repeat (2) @(negedge clk);
        check(code_valid == 1'b1 && code_out == 12'd80, "R8 held start", code_out, 80);
        @(negedge clk);

        // Constrained random intervals
        for (int n = 0; n < 40; n++) begin
            run(int'($urandom_range(1, 60)),
                therm(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1))),
                therm(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1))),
                0, "R3 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule